// File: doc/BRIEF.md
# Paired Sample FIFO with Status Interrupt

This block buffers audio samples for a sound generator in two independent byte-wide queues, called channel A and channel B. A host writes bytes in; a sample consumer pops them out at its own pace. Each channel keeps a fill count and two status flags. The first flag tracks whether the channel is at most half full. The second flag is shared: it marks either that the channel has just become full or that it has just run empty. Both channels drive one common interrupt line. A status byte gathers all four flags, and reading that byte clears them.

A 2-bit mode value selects how host writes are handled. In streaming mode (value 1), a write pushes the byte onto the tail of the chosen channel. In every other mode, a write stores the byte at an explicit address inside the channel's buffer, which a separate read port can look at. Both channels are emptied when the host writes a control byte with its top bit set, or when the host changes the mode to a different value. The half-level interrupt can be masked per channel. After reset the mask lets the interrupt through on both channels.

Top module: `snd_fifo_pair`

## Requirements
- R1: After reset, the status byte reads 0x00, `irq` is low, the mode is 0, and both half-level interrupt enables are 1.
- R2: In mode 1, each channel returns its bytes in the order they were written, independently of the other channel. The 1024-entry storage is reused circularly.
- R3: After any cycle that changes a channel's count, the channel's half flag is 1 if the new count is 511 or less and 0 otherwise. A cycle in which a push and a pop on the same channel both take effect also updates the half flag.
- R4: A push that makes the count exactly 512, or a pop that makes it exactly 511, raises `irq` on the next edge if that channel's enable bit (`ien_wdata[0]` for A, `[1]` for B) is 1. It does not raise `irq` if the bit is 0.
- R5: A push that makes the count 1023, or a pop that makes it 0, sets that channel's full/empty flag and raises `irq`.
- R6: `stat_byte` carries A's half flag in bit 0, A's full/empty flag in bit 1, B's half flag in bit 2 and B's full/empty flag in bit 3. Bits 7:4 are 0. A cycle with `stat_rd` high clears all four flags and lowers `irq`, except for any flag or interrupt that an event in the same cycle sets.
- R7: A control write with bit 7 set empties both channels, clears all flags and lowers `irq`. Any host write or pop in that cycle is discarded. A control write with bit 7 clear has no effect.
- R8: A mode write with a value different from the current mode acts like R7 and stores the new mode. A mode write with the same value changes nothing.
- R9: When the mode is not 1, a host write stores the byte at `host_addr` of the selected channel and leaves its count and flags alone. `rd_data` shows the byte stored at `rd_addr` of channel `rd_sel` in the same cycle.
- R10: A pop on an empty channel, or a pop in any mode other than 1, has no effect, and that channel's pop data reads 0x80.
- R11: A push into a channel that already holds 1024 bytes is dropped.
- R12: If a push and a pop on the same channel both take effect in one cycle, the count does not change and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | New mode value |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control byte; bit 7 requests an empty of both channels |
| ien_wr | input | 1 | Half-interrupt enable write strobe |
| ien_wdata | input | 2 | Enables, bit 0 channel A, bit 1 channel B |
| host_wr | input | 1 | Host byte write strobe |
| host_sel | input | 1 | Target channel, 0 = A, 1 = B |
| host_addr | input | 10 | Buffer address used outside mode 1 |
| host_wdata | input | 8 | Byte to write |
| rd_sel | input | 1 | Channel for the buffer read port |
| rd_addr | input | 10 | Buffer address for the read port |
| rd_data | output | 8 | Byte stored at `rd_addr` |
| pop_req | input | 2 | Pop strobes, bit 0 channel A, bit 1 channel B |
| pop_data_a | output | 8 | Head byte of A, or 0x80 when nothing can be popped |
| pop_data_b | output | 8 | Head byte of B, or 0x80 when nothing can be popped |
| stat_rd | input | 1 | Status read strobe; clears the flags at the edge |
| stat_byte | output | 8 | Combined status flags |
| irq | output | 1 | Shared interrupt, high until cleared |

## Verification
The hardest states to reach are the count boundaries at 511, 512, 1023 and 1024. Random traffic drifts around a near-empty level and almost never climbs that high. For that reason, directed runs fill channel A to capacity with a known byte pattern, push one more byte past full, and then drain A completely. Along the way they read the status at chosen points, so that each interrupt can be traced to the one event that caused it. A second fill of channel B to the half mark, with its enable off, shows that the masked interrupt stays quiet. After the directed runs, a seeded random phase mixes pushes, pops, status reads, rare empties and mode changes so that these operations land in the same cycle.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int unsigned NCH = 2;
  localparam logic [7:0] IDLE_SAMPLE = 8'h80;
  localparam logic [1:0] MODE_STREAM = 2'd1;
  localparam int unsigned CTL_FLUSH_BIT = 7;

  typedef struct packed {
    logic fe;
    logic half;
  } chan_stat_t;
endpackage

// File: rtl/sfp_rst_sync.sv
module sfp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/sfp_ctrl.sv
module sfp_ctrl
  import sfp_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_wr,
  input  logic [1:0]     mode_wdata,
  input  logic           ctl_wr,
  input  logic [7:0]     ctl_wdata,
  input  logic           ien_wr,
  input  logic [NCH-1:0] ien_wdata,
  input  logic           stat_rd,
  input  logic [NCH-1:0] raise,
  output logic           flush,
  output logic           stream_mode,
  output logic [NCH-1:0] half_en,
  output logic           st_clr,
  output logic           irq
);
  logic [1:0]     mode_q, mode_n;
  logic [NCH-1:0] hen_q, hen_n;
  logic           irq_q, irq_n;
  logic           mode_en, hen_en;
  logic           ctl_flush;
  logic           unused_ctl;

  assign unused_ctl = ^ctl_wdata[CTL_FLUSH_BIT-1:0];

  always_comb begin
    ctl_flush = ctl_wr & ctl_wdata[CTL_FLUSH_BIT];
    flush     = ctl_flush | (mode_wr & (mode_wdata != mode_q));
    mode_en   = mode_wr;
    mode_n    = mode_wdata;
    hen_en    = ien_wr;
    hen_n     = ien_wdata;
    if (flush)        irq_n = 1'b0;
    else if (|raise)  irq_n = 1'b1;
    else if (stat_rd) irq_n = 1'b0;
    else              irq_n = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      hen_q  <= '1;
      irq_q  <= 1'b0;
    end else begin
      if (mode_en) mode_q <= mode_n;
      if (hen_en)  hen_q  <= hen_n;
      irq_q <= irq_n;
    end
  end

  assign stream_mode = (mode_q == MODE_STREAM);
  assign half_en     = hen_q;
  assign st_clr      = stat_rd;
  assign irq         = irq_q;

  // R6: a status read with no concurrent event lowers the line
  p_rd_lower_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(|raise)) |=> !irq_q);
  // R7: an empty command always lowers the line
  p_flush_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !irq_q);
  // R4, R5: a channel event raises the line
  p_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|raise) && !flush) |=> irq_q);
  // R8: rewriting the current mode keeps it
  p_mode_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && (mode_wdata == mode_q)) |=> $stable(mode_q));
endmodule

// File: rtl/sfp_chan.sv
module sfp_chan
  import sfp_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          stream_mode,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          pop,
  input  logic          half_en,
  input  logic          st_clr,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] pop_data,
  output chan_stat_t    stat,
  output logic          raise
);
  localparam logic [CW-1:0] CAP       = CW'(DEPTH);
  localparam logic [CW-1:0] FULL_MARK = CW'(DEPTH - 1);
  localparam logic [CW-1:0] HALF_MARK = CW'(DEPTH / 2);
  localparam logic [CW-1:0] LOW_MARK  = CW'(DEPTH / 2 - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_n, rptr_q, rptr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  chan_stat_t    stat_q, stat_n;
  logic          push_ok, pop_ok, dir_wr, any_op;
  logic          ev_half, ev_fe;
  logic          mem_we;
  logic [AW-1:0] mem_wa;

  always_comb begin
    push_ok = ~flush & wr_en & stream_mode & (cnt_q != CAP);
    pop_ok  = ~flush & pop & stream_mode & (cnt_q != '0);
    dir_wr  = ~flush & wr_en & ~stream_mode;
    any_op  = push_ok | pop_ok;

    wptr_n = push_ok ? wptr_q + AW'(1) : wptr_q;
    rptr_n = pop_ok  ? rptr_q + AW'(1) : rptr_q;
    unique case ({push_ok, pop_ok})
      2'b10:   cnt_n = cnt_q + CW'(1);
      2'b01:   cnt_n = cnt_q - CW'(1);
      default: cnt_n = cnt_q;
    endcase

    ev_half = half_en & ((push_ok & ~pop_ok & (cnt_n == HALF_MARK)) |
                         (pop_ok & ~push_ok & (cnt_n == LOW_MARK)));
    ev_fe   = (push_ok & ~pop_ok & (cnt_n == FULL_MARK)) |
              (pop_ok & ~push_ok & (cnt_n == '0));

    stat_n.half = any_op ? (cnt_n <= LOW_MARK) : (~st_clr & stat_q.half);
    stat_n.fe   = ev_fe | (~st_clr & stat_q.fe);

    if (flush) begin
      wptr_n = '0;
      rptr_n = '0;
      cnt_n  = '0;
      stat_n = '0;
    end

    raise  = ev_half | ev_fe;
    mem_we = push_ok | dir_wr;
    mem_wa = push_ok ? wptr_q : wr_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      stat_q <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
      stat_q <= stat_n;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_wa] <= wr_data;
  end

  assign rd_data  = mem[rd_addr];
  assign pop_data = (stream_mode && (cnt_q != '0)) ? mem[rptr_q] : DW'(IDLE_SAMPLE);
  assign stat     = stat_q;

  // R11: the count never exceeds the storage
  p_cnt_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CAP);
  // R11: a push at capacity with no pop leaves the channel full
  p_full_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && stream_mode && !flush && !pop && cnt_q == CAP) |=> cnt_q == CAP);
  // R10: a pop on an empty channel moves nothing
  p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !wr_en && !flush && cnt_q == '0) |=> (cnt_q == '0) && $stable(rptr_q));
  // R7: an empty command clears count and flags
  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0) && (stat_q == '0));
  // R5: reaching one below capacity sets full/empty
  p_fe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok && cnt_q == CAP - CW'(2)) |=> stat_q.fe);
  // R3: the half flag follows the new count after a single operation
  p_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok ^ pop_ok) |=> stat_q.half == (cnt_q <= LOW_MARK));
endmodule

// File: rtl/snd_fifo_pair.sv
module snd_fifo_pair
  import sfp_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_wr,
  input  logic [1:0]     mode_wdata,
  input  logic           ctl_wr,
  input  logic [7:0]     ctl_wdata,
  input  logic           ien_wr,
  input  logic [1:0]     ien_wdata,
  input  logic           host_wr,
  input  logic           host_sel,
  input  logic [AW-1:0]  host_addr,
  input  logic [DW-1:0]  host_wdata,
  input  logic           rd_sel,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  input  logic [1:0]     pop_req,
  output logic [DW-1:0]  pop_data_a,
  output logic [DW-1:0]  pop_data_b,
  input  logic           stat_rd,
  output logic [7:0]     stat_byte,
  output logic           irq
);
  logic           rst_n_s;
  logic           flush, stream_mode, st_clr;
  logic [NCH-1:0] half_en, ch_raise;
  logic [DW-1:0]  ch_rd  [NCH];
  logic [DW-1:0]  ch_pop [NCH];
  chan_stat_t     ch_stat [NCH];

  sfp_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  sfp_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .mode_wr     (mode_wr),
    .mode_wdata  (mode_wdata),
    .ctl_wr      (ctl_wr),
    .ctl_wdata   (ctl_wdata),
    .ien_wr      (ien_wr),
    .ien_wdata   (ien_wdata),
    .stat_rd     (stat_rd),
    .raise       (ch_raise),
    .flush       (flush),
    .stream_mode (stream_mode),
    .half_en     (half_en),
    .st_clr      (st_clr),
    .irq         (irq)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    sfp_chan #(.DEPTH(DEPTH), .DW(DW)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n_s),
      .flush       (flush),
      .stream_mode (stream_mode),
      .wr_en       (host_wr && (host_sel == 1'(g))),
      .wr_addr     (host_addr),
      .wr_data     (host_wdata),
      .pop         (pop_req[g]),
      .half_en     (half_en[g]),
      .st_clr      (st_clr),
      .rd_addr     (rd_addr),
      .rd_data     (ch_rd[g]),
      .pop_data    (ch_pop[g]),
      .stat        (ch_stat[g]),
      .raise       (ch_raise[g])
    );
  end

  always_comb begin
    stat_byte = '0;
    for (int i = 0; i < NCH; i++) stat_byte[2*i +: 2] = ch_stat[i];
  end

  assign rd_data    = ch_rd[rd_sel];
  assign pop_data_a = ch_pop[0];
  assign pop_data_b = ch_pop[1];
endmodule

// File: tb/tb_snd_fifo_pair.sv
module tb_snd_fifo_pair;
  localparam int DEPTH = 1024;

  logic       clk, rst_n;
  logic       mode_wr, ctl_wr, ien_wr, host_wr, host_sel, rd_sel, stat_rd;
  logic [1:0] mode_wdata, ien_wdata, pop_req;
  logic [7:0] ctl_wdata, host_wdata, rd_data, pop_data_a, pop_data_b, stat_byte;
  logic [9:0] host_addr, rd_addr;
  logic       irq;

  snd_fifo_pair dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int         m_cnt [2], m_wp [2], m_rp [2];
  logic [7:0] m_mem [2][DEPTH];
  bit         m_ok  [2][DEPTH];
  bit         m_half [2], m_fe [2];
  bit         m_irq;
  logic [1:0] m_mode, m_hen;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_pop(int i);
    return (m_mode == 2'd1 && m_cnt[i] != 0) ? m_mem[i][m_rp[i]] : 8'h80;
  endfunction

  function automatic logic [7:0] exp_stat();
    return {4'b0, m_fe[1], m_half[1], m_fe[0], m_half[0]};
  endfunction

  task automatic clear_inputs();
    mode_wr = 0; mode_wdata = 0; ctl_wr = 0; ctl_wdata = 0; ien_wr = 0; ien_wdata = 0;
    host_wr = 0; host_sel = 0; host_addr = 0; host_wdata = 0; rd_sel = 0; rd_addr = 0;
    pop_req = 0; stat_rd = 0;
  endtask

  task automatic model_update();
    bit flush, push_ok, pop_ok;
    int nc;
    flush = (ctl_wr && ctl_wdata[7]) || (mode_wr && mode_wdata != m_mode);
    if (flush) begin
      for (int i = 0; i < 2; i++) begin
        m_cnt[i] = 0; m_wp[i] = 0; m_rp[i] = 0; m_half[i] = 0; m_fe[i] = 0;
      end
      m_irq = 0;
    end else begin
      if (stat_rd) begin
        m_irq = 0;
        for (int i = 0; i < 2; i++) begin m_half[i] = 0; m_fe[i] = 0; end
      end
      for (int i = 0; i < 2; i++) begin
        push_ok = host_wr && host_sel == i[0] && m_mode == 2'd1 && m_cnt[i] < DEPTH;
        pop_ok  = pop_req[i] && m_mode == 2'd1 && m_cnt[i] != 0;
        if (host_wr && host_sel == i[0] && m_mode != 2'd1) begin
          m_mem[i][host_addr] = host_wdata;
          m_ok[i][host_addr]  = 1;
        end
        if (push_ok) begin
          m_mem[i][m_wp[i]] = host_wdata;
          m_ok[i][m_wp[i]]  = 1;
          m_wp[i] = (m_wp[i] + 1) % DEPTH;
        end
        if (pop_ok) m_rp[i] = (m_rp[i] + 1) % DEPTH;
        nc = m_cnt[i] + int'(push_ok) - int'(pop_ok);
        if (push_ok || pop_ok) m_half[i] = (nc <= 511);
        if (push_ok && !pop_ok) begin
          if (nc == 512 && m_hen[i]) m_irq = 1;
          if (nc == 1023) begin m_fe[i] = 1; m_irq = 1; end
        end
        if (pop_ok && !push_ok) begin
          if (nc == 511 && m_hen[i]) m_irq = 1;
          if (nc == 0) begin m_fe[i] = 1; m_irq = 1; end
        end
        m_cnt[i] = nc;
      end
    end
    if (mode_wr) m_mode = mode_wdata;
    if (ien_wr)  m_hen  = ien_wdata;
  endtask

  // Inputs are set by the caller after a falling edge; this checks, clocks and clears.
  task automatic tick();
    #1;
    chk(pop_data_a, exp_pop(0), "R2 R10 pop data A");
    chk(pop_data_b, exp_pop(1), "R2 R10 pop data B");
    chk(stat_byte, exp_stat(), "R3 R5 R6 status byte");
    chk(irq, m_irq, "R4 R5 R6 irq");
    if (m_ok[rd_sel][rd_addr]) chk(rd_data, m_mem[rd_sel][rd_addr], "R9 read port");
    @(posedge clk);
    model_update();
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic push(int ch, logic [7:0] d);
    host_wr = 1; host_sel = ch[0]; host_wdata = d; tick();
  endtask

  task automatic popc(int ch);
    pop_req = 2'(1 << ch); tick();
  endtask

  task automatic read_stat();
    stat_rd = 1; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] last_byte;
    void'($urandom(32'd7361));
    clear_inputs();
    rst_n = 0;
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = 0; m_wp[i] = 0; m_rp[i] = 0; m_half[i] = 0; m_fe[i] = 0;
      for (int a = 0; a < DEPTH; a++) m_ok[i][a] = 0;
    end
    m_irq = 0; m_mode = 0; m_hen = 2'b11;
    repeat (5) @(negedge clk);
    #1;
    chk(stat_byte, 8'h00, "R1 status after reset");
    chk(irq, 1'b0, "R1 irq after reset");
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R10: pops in mode 0 give the idle byte
    pop_req = 2'b11; tick();
    chk(pop_data_a, 8'h80, "R10 pop in mode 0");

    // R9: addressed write outside streaming mode
    host_wr = 1; host_sel = 1; host_addr = 10'd5; host_wdata = 8'h3C; tick();
    rd_sel = 1; rd_addr = 10'd5; #1;
    chk(rd_data, 8'h3C, "R9 addressed write readback");
    chk(pop_data_b, 8'h80, "R9 count untouched");
    tick();

    // enter streaming mode
    mode_wr = 1; mode_wdata = 2'd1; tick();

    // R8: same-value mode write keeps contents
    push(0, 8'hA1); push(0, 8'hA2); push(0, 8'hA3);
    mode_wr = 1; mode_wdata = 2'd1; tick();
    #1;
    chk(pop_data_a, 8'hA1, "R8 same mode keeps head");
    chk(stat_byte[0], 1'b1, "R8 same mode keeps half flag");
    read_stat();

    // Fill A to capacity: R1 default enable, R4, R5, R11
    for (int k = 3; k < DEPTH; k++) begin
      push(0, 8'(k * 7 + 3));
      if (m_cnt[0] == 500) read_stat();
      if (m_cnt[0] == 512) begin
        #1; chk(irq, 1'b1, "R1 R4 half irq on push to 512 with default enable");
        chk(stat_byte[0], 1'b0, "R3 half flag clear above 511");
        read_stat();
        #1; chk(irq, 1'b0, "R6 read lowers irq");
      end
      if (m_cnt[0] == 1023) begin
        #1; chk(stat_byte[1], 1'b1, "R5 full flag at 1023");
        chk(irq, 1'b1, "R5 irq at 1023");
        read_stat();
      end
    end
    last_byte = 8'((DEPTH - 1) * 7 + 3);
    push(0, 8'hEE);  // dropped: R11
    #1; chk(irq, 1'b0, "R11 drop raises nothing");

    // Drain A: R2, R4, R5, R11
    while (m_cnt[0] > 0) begin
      if (m_cnt[0] == 1) begin
        #1; chk(pop_data_a, last_byte, "R11 last byte is the one before the drop");
      end
      popc(0);
      if (m_cnt[0] == 600) read_stat();
      if (m_cnt[0] == 511) begin
        #1; chk(irq, 1'b1, "R4 half irq on pop to 511");
        read_stat();
      end
      if (m_cnt[0] == 0) begin
        #1; chk(stat_byte[1], 1'b1, "R5 empty flag at 0");
        chk(irq, 1'b1, "R5 irq at empty");
      end
    end
    popc(0);
    read_stat();

    // R12: simultaneous push and pop on B
    for (int k = 0; k < 10; k++) push(1, 8'(k + 16));
    read_stat();
    host_wr = 1; host_sel = 1; host_wdata = 8'h77; pop_req = 2'b10; tick();
    #1; chk(irq, 1'b0, "R12 no irq on push with pop");
    chk(pop_data_b, 8'h11, "R12 head advanced by one");

    // R4 with enable off on B
    ien_wr = 1; ien_wdata = 2'b01; tick();
    read_stat();
    while (m_cnt[1] < 512) push(1, 8'(m_cnt[1]));
    #1; chk(irq, 1'b0, "R4 masked half irq stays low");
    ien_wr = 1; ien_wdata = 2'b11; tick();

    // R7: control byte
    ctl_wr = 1; ctl_wdata = 8'h7F; tick();
    #1; chk(pop_data_b, 8'h11, "R7 control without bit 7 ignored");
    ctl_wr = 1; ctl_wdata = 8'h80; host_wr = 1; host_sel = 0; host_wdata = 8'h55; tick();
    #1; chk(pop_data_b, 8'h80, "R7 B emptied");
    chk(pop_data_a, 8'h80, "R7 concurrent push discarded");
    chk(stat_byte, 8'h00, "R7 flags cleared");

    // Random phase
    for (int n = 0; n < 6000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 60) begin
        host_wr = 1; host_sel = 1'($urandom_range(0, 1));
        host_addr = 10'($urandom); host_wdata = 8'($urandom);
      end
      pop_req = 2'($urandom_range(0, 3)) & (($urandom_range(0, 9) < 4) ? 2'b11 : 2'b00);
      stat_rd = ($urandom_range(0, 9) == 0);
      rd_sel = 1'($urandom); rd_addr = 10'($urandom_range(0, 15));
      if ($urandom_range(0, 255) == 0) begin ctl_wr = 1; ctl_wdata = 8'($urandom); end
      if ($urandom_range(0, 299) == 0) begin
        mode_wr = 1; mode_wdata = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'd1;
      end
      if ($urandom_range(0, 63) == 0) begin ien_wr = 1; ien_wdata = 2'($urandom); end
      if (m_mode != 2'd1 && $urandom_range(0, 49) == 0) begin mode_wr = 1; mode_wdata = 2'd1; end
      tick();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule